// File: doc/BRIEF.md
# Dual-Sequence Two-Bit Counter

This block is a small synchronous counter whose state is its own output. A mode input picks one of two successor orders. With the mode low, the value walks up in plain binary order. With the mode high, it walks the reflected Gray order, in which adjacent values differ in one bit. An enable input lets the surrounding logic pause the count, and a synchronous active-high reset returns it to zero.

The mode input affects only the next step. It does not restart the count. On each enabled clock edge, the next value is the successor of the present value in whichever order the mode selects at that edge. No memory of earlier modes is kept, so a mode change in mid-count simply continues from the current value in the new order.

Top module: `dual_seq_counter`

## Requirements
- R1: A high `rst` at a rising clock edge sets `cntOut` to 2'b00 at that edge.
- R2: With `grayMode` = 0 and `cntEn` = 1, each rising edge moves `cntOut` through 00 → 01 → 10 → 11 → 00.
- R3: With `grayMode` = 1 and `cntEn` = 1, each rising edge moves `cntOut` through 00 → 01 → 11 → 10 → 00.
- R4: When `grayMode` differs from its value at the previous edge, the next value is the successor of the present value in the newly selected order. For example, 01 followed by a switch to Gray gives 11, and 10 followed by a switch to binary gives 11.
- R5: With `cntEn` = 0 and `rst` = 0, `cntOut` keeps its value across the edge, whatever the value of `grayMode`.
- R6: In Gray mode, every enabled step changes exactly one bit of `cntOut`, and this includes the wrap from 10 to 00.
- R7: Reset takes priority over a low `cntEn`: `rst` = 1 clears `cntOut` even when the count is paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 00 |
| cntEn | input | 1 | Advance enable; when low, the count holds |
| grayMode | input | 1 | 0 selects binary order, 1 selects Gray order |
| cntOut | output | 2 | Present count, which is also the state |

## Verification
The output is the state itself, so a wrong next-state value shows on `cntOut` one sample after the edge that produced it. There is no hidden state that could mask an error. A fault that applies only to one order, or only to one value pair (for example, the Gray wrap from 10 to 00, or the binary step out of 01 after a mode change), shows only when that exact value and mode meet at an edge. For this reason the stimulus crosses every value with both modes and with the enable held low.

// File: rtl/dual_seq_counter_pkg.sv
package dual_seq_counter_pkg;
  typedef struct packed {
    logic clear;
    logic step;
    logic useGray;
  } cnt_ctl_t;
endpackage

// File: rtl/dual_seq_counter_ctrl.sv
module dual_seq_counter_ctrl
  import dual_seq_counter_pkg::*;
(
  input  logic     rst,
  input  logic     cntEn,
  input  logic     grayMode,
  output cnt_ctl_t ctl
);
  always_comb begin
    ctl.clear   = rst;
    ctl.step    = cntEn & ~rst;
    ctl.useGray = grayMode;
  end
endmodule

// File: rtl/dual_seq_counter_dp.sv
module dual_seq_counter_dp
  import dual_seq_counter_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  cnt_ctl_t         ctl,
  output logic [CNT_W-1:0] cntQ
);
  localparam int TOP = CNT_W - 1;

  logic [CNT_W-1:0] asBin;
  logic [CNT_W-1:0] binInc;
  logic [CNT_W-1:0] grayFromInc;
  logic [CNT_W-1:0] plainInc;
  logic [CNT_W-1:0] nextVal;

  // Gray-to-binary prefix XOR chain, one stage per bit.
  assign asBin[TOP] = cntQ[TOP];
  genvar gi;
  generate
    for (gi = TOP - 1; gi >= 0; gi--) begin : g_g2b
      assign asBin[gi] = asBin[gi+1] ^ cntQ[gi];
    end
  endgenerate

  always_comb begin
    binInc      = asBin + CNT_W'(1);
    grayFromInc = binInc ^ (binInc >> 1);
    plainInc    = cntQ + CNT_W'(1);
    nextVal     = ctl.useGray ? grayFromInc : plainInc;
  end

  always_ff @(posedge clk) begin
    if (ctl.clear)     cntQ <= '0;
    else if (ctl.step) cntQ <= nextVal;
  end
endmodule

// File: rtl/dual_seq_counter.sv
module dual_seq_counter
  import dual_seq_counter_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  logic             grayMode,
  output logic [CNT_W-1:0] cntOut
);
  cnt_ctl_t ctl;

  dual_seq_counter_ctrl u_ctrl (
    .rst      (rst),
    .cntEn    (cntEn),
    .grayMode (grayMode),
    .ctl      (ctl)
  );

  dual_seq_counter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk  (clk),
    .ctl  (ctl),
    .cntQ (cntOut)
  );
endmodule

// File: rtl/dual_seq_counter_chk.sv
module dual_seq_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cntEn,
  input logic       grayMode,
  input logic [1:0] cntOut
);
  function automatic logic [1:0] graySucc(input logic [1:0] v);
    case (v)
      2'b00:   graySucc = 2'b01;
      2'b01:   graySucc = 2'b11;
      2'b11:   graySucc = 2'b10;
      default: graySucc = 2'b00;
    endcase
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> cntOut == 2'b00);

  // R7
  reset_over_hold_chk: assert property (@(posedge clk)
    (rst && !cntEn) |=> cntOut == 2'b00);

  // R2
  bin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && cntEn && !grayMode) |=> cntOut == 2'($past(cntOut) + 2'd1));

  // R3
  gray_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && cntEn && grayMode) |=> cntOut == graySucc($past(cntOut)));

  // R6
  gray_onebit_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && cntEn && grayMode) |=> $countones(cntOut ^ $past(cntOut)) == 1);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cntEn) |=> $stable(cntOut));
endmodule

bind dual_seq_counter dual_seq_counter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cntEn    (cntEn),
  .grayMode (grayMode),
  .cntOut   (cntOut)
);

// File: tb/sim_dual_seq_counter.sv
module sim_dual_seq_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  // Vector layout: {rst, cntEn, grayMode, expected[1:0]}
  localparam logic [4:0] VEC [NV] = '{
    5'b1_0_0_00, // R7 reset while paused
    5'b0_1_0_01, 5'b0_1_0_10, 5'b0_1_0_11, 5'b0_1_0_00, // R2
    5'b0_1_1_01, 5'b0_1_1_11, 5'b0_1_1_10, 5'b0_1_1_00, // R3
    5'b0_1_0_01, 5'b0_1_1_11, // R4 binary to Gray from 01
    5'b0_1_1_10, 5'b0_1_0_11, // R4 Gray to binary from 10
    5'b0_1_0_00,
    5'b0_0_1_00, 5'b0_1_0_01, 5'b0_0_0_01, 5'b0_0_1_01, // R5
    5'b0_1_1_11, 5'b0_1_0_00, // R4 Gray to binary from 11
    5'b0_1_0_01, 5'b0_1_0_10, 5'b0_1_1_00, // R4 binary to Gray from 10
    5'b1_1_1_00  // R1
  };
  localparam string TAG [NV] = '{
    "R7", "R2", "R2", "R2", "R2", "R3", "R3", "R3", "R3",
    "R2", "R4", "R3", "R4", "R2", "R5", "R2", "R5", "R5",
    "R3", "R4", "R2", "R2", "R4", "R1"
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntEn = 1'b0;
  logic       grayMode = 1'b0;
  logic [1:0] cntOut;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_seq_counter u0 (
    .clk(clk), .rst(rst), .cntEn(cntEn), .grayMode(grayMode), .cntOut(cntOut)
  );

  task automatic check(input string tag, input logic [1:0] exp);
    nChecks++;
    if (cntOut !== exp) begin
      nFails++;
      $display("FAIL %s: cntOut=%b expected=%b", tag, cntOut, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic m);
    rst = r; cntEn = e; grayMode = m;
    @(negedge clk);
  endtask

  initial begin
    logic [1:0] prev;
    @(negedge clk);
    step(1'b1, 1'b1, 1'b0);
    check("R1", 2'b00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      check(TAG[i], VEC[i][1:0]);
    end

    // R6: one-bit change on every Gray step across two full laps
    for (int i = 0; i < 8; i++) begin
      prev = cntOut;
      step(1'b0, 1'b1, 1'b1);
      nChecks++;
      if ($countones(cntOut ^ prev) != 1) begin
        nFails++;
        $display("FAIL R6: %b -> %b, expected one bit changed", prev, cntOut);
      end
    end

    // R5: a long pause at 11 with the mode toggling
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0);
    check("R2", 2'b11);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'(i));
      check("R5", 2'b11);
    end
    // R4: binary wrap from 11 versus Gray successor of 11
    step(1'b0, 1'b1, 1'b1);
    check("R4", 2'b10);
    // R7: reset while paused from a nonzero value
    step(1'b1, 1'b0, 1'b1);
    check("R7", 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule